// File: doc/BRIEF.md
# Address-Pattern Memory BIST Engine

This block is a self-contained memory test sequencer. It sits in front of a simple synchronous memory port that has byte enables and a one-cycle read latency. After a start pulse it walks from a start address towards an end address in blocks of a fixed size (1024 bytes by default). It first fills each block completely with a pattern derived from the addresses, then reads the whole block back and compares every element. It then moves on to the next block.

Consecutive blocks cycle through four patterns, each with its own access width. The first writes full words holding their own address. The second writes full words holding the inverted address. The third writes halfwords holding the low address half. The fourth writes bytes holding the low address byte. A quick mode keeps the first pattern on every block.

The engine stops with a pass as soon as the next block would start at or past the end address. It stops with a fail at the first read that does not match. On a fail it keeps the failing address, the expected value and the observed value.

The controller has six states. ST_IDLE waits for start. ST_WRITE issues one write per cycle. ST_READ issues one read. ST_CHECK compares the returned data. ST_ADVANCE decides between the next block and the end of the test. ST_DONE holds the result.

The transitions are:
- IDLE→WRITE on start.
- WRITE→READ after the last element of the block.
- READ→CHECK always.
- CHECK→READ on a match that is not the last element.
- CHECK→ADVANCE on a match of the last element.
- CHECK→DONE on a mismatch.
- ADVANCE→WRITE when the next block is still below the end address.
- ADVANCE→DONE when it is not.
- DONE→WRITE on a new start.

Top module: `mbist_engine`

## Requirements
- R1: A start pulse in ST_IDLE or ST_DONE latches start_addr, end_addr and quick, raises busy in the next cycle, and clears done, pass and fail. A start pulse while busy is ignored and does not change the run in progress.
- R2: Each block spans BLK_BYTES bytes, and every write of a block is issued before any read of that block. Each block gets exactly one write and one read per element: 256 in the word phases, 512 in the halfword phase and 1024 in the byte phase.
- R3: Word phase, code 0. Each 4-byte-aligned address A receives a full-word write of the zero-extended A with mem_be = 4'b1111. mem_addr is a byte address, and byte lane n (bits 8n+7:8n) holds the byte at word address + n.
- R4: Inverted phase, code 1. Each 4-byte-aligned address A receives a full-word write of the bitwise inverse of the zero-extended A with mem_be = 4'b1111.
- R5: Halfword phase, code 2. Each 2-byte-aligned address A receives A[15:0] in lanes 1:0 with mem_be = 4'b0011 when A[1] = 0, or in lanes 3:2 with mem_be = 4'b1100 when A[1] = 1.
- R6: Byte phase, code 3. Each address A receives A[7:0] in lane A[1:0], with mem_be one-hot at bit A[1:0].
- R7: Without quick mode, block k after the start address (k = 0, 1, ...) uses phase k mod 4. After the byte phase the rotation returns to the word phase.
- R8: In quick mode every block uses the word phase.
- R9: After each block the block start advances by BLK_BYTES. The test ends with pass when the new block start is greater than or equal to the end address. The first block is always run, even when start_addr >= end_addr.
- R10: The first read whose selected lanes differ from the expected value ends the test with fail, and no further memory request follows. fail_addr holds the byte address, fail_expect the expected value and fail_observed the read value. Both values are zero-extended to the access width (lanes 3:2 or 3 shifted down to bit 0).
- R11: After reset, busy, done, pass, fail and mem_req are low. Once a test ends, done and exactly one of pass or fail stay high, with the captured values unchanged, until the next start.
- R12: A mismatch on the very last read of the final block reports fail, not pass.
- R13: start_addr is expected to be word aligned. Under that condition every full-word access is at an address with bits 1:0 equal to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle start pulse |
| start_addr | input | ADDR_W | First block start (byte address) |
| end_addr | input | ADDR_W | End address used by the termination rule |
| quick | input | 1 | Word phase only when high |
| busy | output | 1 | Test in progress |
| done | output | 1 | Test finished, held until next start |
| pass | output | 1 | Finished without mismatch |
| fail | output | 1 | Finished on a mismatch |
| fail_addr | output | ADDR_W | Byte address of the first mismatch |
| fail_expect | output | 32 | Expected value at the first mismatch |
| fail_observed | output | 32 | Observed value at the first mismatch |
| mem_req | output | 1 | Memory request strobe |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | 32 | Write data, pattern replicated across lanes |
| mem_be | output | 4 | Byte-lane enables |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |

## Verification
Two decisions can meet in one cycle: the mismatch on a read and the end-of-block decision that leads to termination. This happens when the very last element of the final block is corrupted. The bench provokes it by flipping a bit on the read path of the last word of a one-block run, and of the last byte of a four-block run that ends in the byte phase. In both cases it expects fail with no pass, the exact failing address and both values. Fault runs in each of the four phases also check that the read count stops at the failing element.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

    typedef enum logic [1:0] {
        PH_WORD = 2'd0,
        PH_INV  = 2'd1,
        PH_HALF = 2'd2,
        PH_BYTE = 2'd3
    } phase_t;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_WRITE   = 3'd1,
        ST_READ    = 3'd2,
        ST_CHECK   = 3'd3,
        ST_ADVANCE = 3'd4,
        ST_DONE    = 3'd5
    } state_t;

    // Address step, in bytes, for one access of the given phase
    function automatic logic [2:0] stride_of(phase_t ph);
        unique case (ph)
            PH_WORD, PH_INV: stride_of = 3'd4;
            PH_HALF:         stride_of = 3'd2;
            default:         stride_of = 3'd1;
        endcase
    endfunction

endpackage

// File: rtl/mbist_pattern.sv
module mbist_pattern
    import mbist_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  phase_t              phase,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [31:0]         rdata,
    output logic [31:0]         wdata,
    output logic [3:0]          be,
    output logic [31:0]         expect_val,
    output logic [31:0]         observed
);
    localparam int LANES = 4;

    logic [31:0] a32;
    logic [7:0]  lane [LANES];
    logic [15:0] half_lo;
    logic [15:0] half_hi;

    assign a32 = 32'(addr);

    // Split the returned word into byte lanes
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane[g] = rdata[8*g +: 8];
    end

    assign half_lo = {lane[1], lane[0]};
    assign half_hi = {lane[3], lane[2]};

    always_comb begin
        wdata      = a32;
        be         = 4'b1111;
        expect_val = a32;
        observed   = rdata;
        unique case (phase)
            PH_WORD: begin
                wdata      = a32;
                expect_val = a32;
                observed   = rdata;
            end
            PH_INV: begin
                wdata      = ~a32;
                expect_val = ~a32;
                observed   = rdata;
            end
            PH_HALF: begin
                wdata      = {a32[15:0], a32[15:0]};
                be         = addr[1] ? 4'b1100 : 4'b0011;
                expect_val = {16'h0000, a32[15:0]};
                observed   = {16'h0000, addr[1] ? half_hi : half_lo};
            end
            PH_BYTE: begin
                wdata      = {4{a32[7:0]}};
                be         = 4'b0001 << addr[1:0];
                expect_val = {24'h000000, a32[7:0]};
                observed   = {24'h000000, lane[addr[1:0]]};
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/mbist_walker.sv
module mbist_walker
    import mbist_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int BLK_BYTES = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic              advance,
    input  logic [ADDR_W-1:0] ld_start,
    input  logic [ADDR_W-1:0] ld_end,
    input  logic              ld_quick,
    output phase_t            phase,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              last_elem,
    output logic              finish
);
    localparam int OFFS_W = $clog2(BLK_BYTES);

    logic [ADDR_W-1:0] blk_q;
    logic [ADDR_W-1:0] end_q;
    logic              quick_q;
    logic [OFFS_W-1:0] offs_q;
    phase_t            phase_q;

    logic [OFFS_W:0]   offs_next;
    logic [ADDR_W:0]   blk_next;
    phase_t            phase_next;

    assign offs_next = {1'b0, offs_q} + (OFFS_W+1)'(stride_of(phase_q));
    assign last_elem = (offs_next == (OFFS_W+1)'(BLK_BYTES));
    assign blk_next  = {1'b0, blk_q} + (ADDR_W+1)'(BLK_BYTES);
    assign finish    = (blk_next >= {1'b0, end_q});
    assign cur_addr  = blk_q + ADDR_W'(offs_q);
    assign phase     = phase_q;

    always_comb begin
        if (quick_q) phase_next = PH_WORD;
        else         phase_next = phase_t'(2'(phase_q) + 2'd1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blk_q   <= '0;
            end_q   <= '0;
            quick_q <= 1'b0;
            offs_q  <= '0;
            phase_q <= PH_WORD;
        end else if (load) begin
            blk_q   <= ld_start;
            end_q   <= ld_end;
            quick_q <= ld_quick;
            offs_q  <= '0;
            phase_q <= PH_WORD;
        end else if (advance) begin
            blk_q   <= blk_next[ADDR_W-1:0];
            offs_q  <= '0;
            phase_q <= phase_next;
        end else if (step) begin
            offs_q  <= last_elem ? '0 : offs_next[OFFS_W-1:0];
        end
    end

    // R8: a quick run never leaves the word phase
    p_quick_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (quick_q && !load) |=> (phase_q == PH_WORD));

    // R7: the phase moves only at a block boundary, by one step
    p_phase_rotate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !quick_q && !load) |=> (phase_q == phase_t'(2'($past(phase_q)) + 2'd1)));

endmodule

// File: rtl/mbist_capture.sv
module mbist_capture #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              cap,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [31:0]       in_expect,
    input  logic [31:0]       in_observed,
    output logic              mismatch,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [31:0]       fail_expect,
    output logic [31:0]       fail_observed
);
    assign mismatch = (in_expect != in_observed);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fail_addr     <= '0;
            fail_expect   <= '0;
            fail_observed <= '0;
        end else if (clr) begin
            fail_addr     <= '0;
            fail_expect   <= '0;
            fail_observed <= '0;
        end else if (cap) begin
            fail_addr     <= in_addr;
            fail_expect   <= in_expect;
            fail_observed <= in_observed;
        end
    end

endmodule

// File: rtl/mbist_fsm.sv
module mbist_fsm
    import mbist_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic last_elem,
    input  logic finish,
    input  logic mismatch,
    output logic load,
    output logic step,
    output logic advance,
    output logic capture,
    output logic mem_req,
    output logic mem_we,
    output logic busy,
    output logic done,
    output logic pass,
    output logic fail
);
    state_t state_q;
    state_t state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_WRITE;
            ST_WRITE:   if (last_elem) state_d = ST_READ;
            ST_READ:    state_d = ST_CHECK;
            ST_CHECK: begin
                if (mismatch)       state_d = ST_DONE;
                else if (last_elem) state_d = ST_ADVANCE;
                else                state_d = ST_READ;
            end
            ST_ADVANCE: state_d = finish ? ST_DONE : ST_WRITE;
            ST_DONE:    if (start) state_d = ST_WRITE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        load    = 1'b0;
        step    = 1'b0;
        advance = 1'b0;
        capture = 1'b0;
        mem_req = 1'b0;
        mem_we  = 1'b0;
        busy    = 1'b1;
        done    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
                load = start;
            end
            ST_WRITE: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                step    = 1'b1;
            end
            ST_READ: begin
                mem_req = 1'b1;
            end
            ST_CHECK: begin
                capture = mismatch;
                step    = !mismatch && !last_elem;
            end
            ST_ADVANCE: begin
                advance = !finish;
            end
            ST_DONE: begin
                busy = 1'b0;
                done = 1'b1;
                load = start;
            end
            default: busy = 1'b0;
        endcase
    end

    // Result flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pass <= 1'b0;
            fail <= 1'b0;
        end else if (load) begin
            pass <= 1'b0;
            fail <= 1'b0;
        end else if (state_q == ST_CHECK && mismatch) begin
            fail <= 1'b1;
        end else if (state_q == ST_ADVANCE && finish) begin
            pass <= 1'b1;
        end
    end

    // R12: pass and fail never both set
    p_one_verdict_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass && fail));

    // R11: a finished result is held while no start arrives
    p_done_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(pass) && $stable(fail)));

    // R10: nothing is requested once the test is over
    p_quiet_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req);

    // R2: every read is followed by its compare cycle
    p_read_check_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READ) |=> (state_q == ST_CHECK));

    // R1: busy and done exclude each other
    p_busy_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

endmodule

// File: rtl/mbist_engine.sv
module mbist_engine
    import mbist_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int BLK_BYTES = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] end_addr,
    input  logic              quick,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [31:0]       fail_expect,
    output logic [31:0]       fail_observed,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    output logic [3:0]        mem_be,
    input  logic [31:0]       mem_rdata
);
    logic        load, step, advance, capture;
    logic        last_elem, finish, mismatch;
    phase_t      phase;
    logic [31:0] expect_val, observed;

    mbist_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .last_elem (last_elem),
        .finish    (finish),
        .mismatch  (mismatch),
        .load      (load),
        .step      (step),
        .advance   (advance),
        .capture   (capture),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .busy      (busy),
        .done      (done),
        .pass      (pass),
        .fail      (fail)
    );

    mbist_walker #(
        .ADDR_W    (ADDR_W),
        .BLK_BYTES (BLK_BYTES)
    ) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step      (step),
        .advance   (advance),
        .ld_start  (start_addr),
        .ld_end    (end_addr),
        .ld_quick  (quick),
        .phase     (phase),
        .cur_addr  (mem_addr),
        .last_elem (last_elem),
        .finish    (finish)
    );

    mbist_pattern #(
        .ADDR_W (ADDR_W)
    ) u_pat (
        .phase      (phase),
        .addr       (mem_addr),
        .rdata      (mem_rdata),
        .wdata      (mem_wdata),
        .be         (mem_be),
        .expect_val (expect_val),
        .observed   (observed)
    );

    mbist_capture #(
        .ADDR_W (ADDR_W)
    ) u_cap (
        .clk           (clk),
        .rst_n         (rst_n),
        .clr           (load),
        .cap           (capture),
        .in_addr       (mem_addr),
        .in_expect     (expect_val),
        .in_observed   (observed),
        .mismatch      (mismatch),
        .fail_addr     (fail_addr),
        .fail_expect   (fail_expect),
        .fail_observed (fail_observed)
    );

    // R13: full-word accesses are word aligned
    p_word_align_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_be == 4'b1111) |-> (mem_addr[1:0] == 2'b00));

    // R5: halfword enables cover an aligned lane pair
    p_half_lanes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && $countones(mem_be) == 2) |-> (mem_be == 4'b0011 || mem_be == 4'b1100));

    // R6: byte enables are one lane or more, never none
    p_be_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 || $countones(mem_be) == 4));

    // R10: a newly reported failure carries differing values
    p_fail_values_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail) |-> (fail_expect != fail_observed));

endmodule

// File: tb/sim_mbist_engine.sv
`timescale 1ns/1ps
module sim_mbist_engine;
    localparam int AW   = 13;
    localparam int BLK  = 1024;
    localparam int NW   = (1 << AW) / 4;
    localparam int NB   = 1 << AW;
    localparam logic [31:0] SENT = 32'hA5C3_5A3C;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [AW-1:0] end_addr = '0;
    logic          quick = 1'b0;
    logic          busy, done, pass, fail;
    logic [AW-1:0] fail_addr;
    logic [31:0]   fail_expect, fail_observed;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic [3:0]    mem_be;
    logic [31:0]   mem_rdata;

    always #2.5 clk = ~clk;

    mbist_engine #(.ADDR_W(AW), .BLK_BYTES(BLK)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .end_addr(end_addr), .quick(quick), .busy(busy), .done(done),
        .pass(pass), .fail(fail), .fail_addr(fail_addr),
        .fail_expect(fail_expect), .fail_observed(fail_observed),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_rdata(mem_rdata)
    );

    // Memory model with a read-path fault
    logic [31:0] mem [NW];
    logic        fill = 1'b0;
    logic        fault_en = 1'b0;
    int          fault_idx = 0;
    logic [31:0] fault_mask = '0;
    int          n_wr = 0, n_rd = 0, n_rw = 0, n_wr2rd = 0;
    logic        last_we = 1'b0;

    always @(posedge clk) begin
        if (fill) begin
            for (int i = 0; i < NW; i++) mem[i] <= SENT;
        end else if (mem_req) begin
            if (mem_we) begin
                for (int n = 0; n < 4; n++)
                    if (mem_be[n]) mem[mem_addr[AW-1:2]][8*n +: 8] <= mem_wdata[8*n +: 8];
            end else begin
                mem_rdata <= mem[mem_addr[AW-1:2]] ^
                    ((fault_en && int'(mem_addr[AW-1:2]) == fault_idx) ? fault_mask : 32'h0);
            end
        end
        if (mem_req) begin
            if (mem_we) n_wr <= n_wr + 1; else n_rd <= n_rd + 1;
            if (mem_we && !last_we) n_rw <= n_rw + 1;
            if (!mem_we && last_we) n_wr2rd <= n_wr2rd + 1;
            last_we <= mem_we;
        end
        if (start) last_we <= 1'b0;
    end

    int checks = 0, failures = 0;
    int s_wr, s_rd, s_rw, s_wr2rd;
    bit timed_out;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input int a, input int ph);
        logic [31:0] w;
        logic [15:0] h;
        w = 32'(a & ~3);
        h = 16'(a & ~1);
        case (ph)
            0: return 8'(w >> (8 * (a & 3)));
            1: return 8'((~w) >> (8 * (a & 3)));
            2: return (a & 1) ? h[15:8] : h[7:0];
            default: return 8'(a);
        endcase
    endfunction

    function automatic int wr_per_block(input int ph);
        return (ph == 2) ? 512 : (ph == 3) ? 1024 : 256;
    endfunction

    task automatic fire(input int s, input int e, input bit q);
        @(negedge clk);
        fill = 1'b1;
        @(negedge clk);
        fill = 1'b0;
        start_addr = AW'(s);
        end_addr   = AW'(e);
        quick      = q;
        s_wr = n_wr; s_rd = n_rd; s_rw = n_rw; s_wr2rd = n_wr2rd;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        int t;
        t = 0;
        timed_out = 1'b0;
        while (!done && t < 40000) begin
            @(negedge clk);
            t++;
        end
        if (!done) begin
            timed_out = 1'b1;
            chk(1'b0, "watchdog", 32'(t), 32'd40000);
        end
    endtask

    // Full passing run, then exhaustive image, count and ordering checks
    task automatic pass_run(input int s, input int e, input bit q, input string tag);
        int last, nblk, ewr, bad, first_bad;
        logic [7:0] got, want;
        fire(s, e, q);
        chk(busy == 1'b1 && done == 1'b0, {tag, " R1 busy after start"}, {busy, done}, 2'b10);
        wait_done();
        if (timed_out) return;
        last = s; nblk = 1;
        ewr = wr_per_block(0);
        while (last + BLK < e) begin
            last += BLK;
            ewr += wr_per_block(q ? 0 : nblk % 4);
            nblk++;
        end
        chk(pass && !fail && !busy, {tag, " R9 pass verdict"}, {pass, fail, busy}, 3'b100);
        chk((n_wr - s_wr) == ewr && (n_rd - s_rd) == ewr, {tag, " R2 write/read counts"},
            32'(n_wr - s_wr), 32'(ewr));
        chk((n_rw - s_rw) == nblk && (n_wr2rd - s_wr2rd) == nblk, {tag, " R2 whole-block ordering"},
            32'(n_wr2rd - s_wr2rd), 32'(nblk));
        bad = 0; first_bad = -1;
        for (int a = 0; a < NB; a++) begin
            got = mem[a >> 2][8 * (a & 3) +: 8];
            if (a >= s && a < last + BLK)
                want = exp_byte(a, q ? 0 : ((a - s) / BLK) % 4);
            else
                want = SENT[8 * (a & 3) +: 8];
            if (got != want) begin
                if (first_bad < 0) first_bad = a;
                bad++;
            end
        end
        chk(bad == 0, q ? {tag, " R8 R3 quick image"} : {tag, " R3 R4 R5 R6 R7 image"},
            32'(first_bad), 32'hFFFF_FFFF);
        repeat (15) @(negedge clk);
        chk(done && pass && !fail && !mem_req, {tag, " R11 result held"}, {done, pass, fail, mem_req}, 4'b1100);
    endtask

    task automatic fault_run(input int s, input int e, input int fidx, input logic [31:0] fm,
                             input int faddr, input logic [31:0] fexp, input logic [31:0] fobs,
                             input int ewr, input int erd, input string tag);
        fault_en = 1'b1; fault_idx = fidx; fault_mask = fm;
        fire(s, e, 1'b0);
        wait_done();
        if (!timed_out) begin
            chk(fail && !pass, {tag, " R10 R12 fail verdict"}, {pass, fail}, 2'b01);
            chk(fail_addr == AW'(faddr), {tag, " R10 fail address"}, 32'(fail_addr), 32'(faddr));
            chk(fail_expect == fexp, {tag, " R10 expected value"}, fail_expect, fexp);
            chk(fail_observed == fobs, {tag, " R10 observed value"}, fail_observed, fobs);
            repeat (10) @(negedge clk);
            chk((n_rd - s_rd) == erd && (n_wr - s_wr) == ewr, {tag, " R10 no access after fail"},
                32'(n_rd - s_rd), 32'(erd));
        end
        fault_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !pass && !fail && !mem_req, "R11 reset state",
            {busy, done, pass, fail, mem_req}, 5'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // Rotation over seven blocks, including a second lap
        pass_run(0, 7000, 1'b0, "rot");
        // Unaligned-to-block word-aligned start
        pass_run(516, 4000, 1'b0, "off");
        // Quick mode
        pass_run(1024, 5000, 1'b1, "quick");
        // End just past start: one block
        pass_run(2048, 2049, 1'b0, "one");
        // Start beyond end: first block still runs (R9)
        pass_run(4096, 100, 1'b0, "inv_range");
        // End exactly on a block boundary
        pass_run(0, 3072, 1'b0, "edge");

        // Start ignored while busy (R1)
        fire(0, 2000, 1'b0);
        repeat (40) @(negedge clk);
        start_addr = AW'(4096); end_addr = AW'(8000); quick = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        chk(pass && (n_wr - s_wr) == 512 && mem[4096 / 4] == SENT, "R1 start while busy ignored",
            32'(n_wr - s_wr), 32'd512);
        // New start clears the held result (R1)
        @(negedge clk);
        start_addr = AW'(0); end_addr = AW'(10); quick = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy && !done && !pass && !fail, "R1 restart clears flags", {busy, done, pass, fail}, 4'b1000);
        wait_done();

        // Faults in each phase
        fault_run(0, 8191, 32'h010 / 4, 32'h0000_0001, 32'h010, 32'h0000_0010, 32'h0000_0011,
                  256, 5, "ph_word R3");
        fault_run(0, 8191, 32'h420 / 4, 32'h0001_0000, 32'h420, 32'hFFFF_FBDF, 32'hFFFE_FBDF,
                  512, 265, "ph_inv R4");
        fault_run(0, 8191, 32'h840 / 4, 32'h0001_0000, 32'h842, 32'h0000_0842, 32'h0000_0843,
                  1024, 546, "ph_half R5");
        fault_run(0, 8191, 32'hC08 / 4, 32'h0100_0000, 32'hC0B, 32'h0000_000B, 32'h0000_000A,
                  2048, 1036, "ph_byte R6");
        // Mismatch on last read of final block (R12)
        fault_run(0, 1024, 32'h3FC / 4, 32'h8000_0000, 32'h3FC, 32'h0000_03FC, 32'h8000_03FC,
                  256, 256, "last_word R12");
        fault_run(0, 4000, 32'hFFC / 4, 32'h0100_0000, 32'hFFF, 32'h0000_00FF, 32'h0000_00FE,
                  2048, 2048, "last_byte R12");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Global watchdog
    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog global actual=expired expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule